// File: doc/BRIEF.md
# Exception State Save/Restore Unit

This block keeps two 32-bit registers for a processor core. The first is the live machine state, which holds the control bits that govern the running context. The second is a save register that captures part of that state when an exception is taken.

An exception-entry strobe does two things in the same clock:
- It snapshots a selected set of state bits into the save register.
- It loads a handler-context state. This state has interrupts disabled, supervisor mode and untranslated addressing, and its byte order comes from the exception-endian bit.

A return strobe copies the saved bits back into the live state. A software write port can load either register directly.

Two combinational gates are driven from the live state:
- One passes external and decrementer interrupt requests only while the interrupt-enable bit is set.
- The other raises a vector-unavailable flag for a decoded vector instruction while the vector-enable bit is clear. Instructions of the data-stream touch/stop class are exempt from this flag.

Bit numbering is big-endian throughout: architectural bit n sits at vector index 31-n.

Top module: `exc_state_unit`

## Requirements
- R1: A synchronous active-low reset clears both registers to 0x00000000. With both registers at zero, interrupts are masked and big-endian order is selected.
- R2: On exception entry the save register receives state bits 6 and 16–31 in the same positions, and bits 0–5 and 7–15 are written as zero (mask 0x0200FFFF).
- R3: On exception entry the new state clears bit 16 (interrupt enable), bit 17 (problem state), bit 26 (instruction relocate) and bit 27 (data relocate). It sets bit 31 (little-endian) equal to bit 15 (exception endian) and keeps every other writable bit unchanged.
- R4: On a return strobe the state register is loaded from the save register, restricted to the writable positions.
- R5: The strobes have a fixed priority: entry beats return, and return beats a software write in the same cycle. A losing software write has no effect on either register.
- R6: When wr_en is set, wr_sel=0 loads the state register and wr_sel=1 loads the save register with all 32 bits.
- R7: Each irq_take bit equals the matching irq_req bit ANDed with state bit 16.
- R8: vec_unavail is 1 exactly when vec_op=1, vec_stream=0 and state bit 6 is 0.
- R9: State bits 0–5 and 7–12 always read as zero whatever is written or restored into them, so the writable mask is 0x0207FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_return | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Software write enable |
| wr_sel | input | 1 | Write target: 0 state, 1 save |
| wr_data | input | 32 | Software write data |
| irq_req | input | N_IRQ | Pending external/decrementer requests |
| vec_op | input | 1 | Decoded vector instruction that touches vector state |
| vec_stream | input | 1 | The decoded instruction is a data-stream touch/stop |
| state_q | output | 32 | Live machine state |
| save_q | output | 32 | Saved status |
| irq_take | output | N_IRQ | Requests qualified by the interrupt-enable bit |
| vec_unavail | output | 1 | Vector-unavailable exception flag |

## Verification
The bench targets several corner cases, each with a distinct symptom if the design gets it wrong:
- Collisions: entry and return in the same cycle, and return with a software write in the same cycle. A wrong priority order would restore stale state or let the write land.
- Save register loaded with all ones, then restored: a missing write mask would leak ones into reserved state bits.
- Endian handling: the exception-endian bit is set with the live endian bit clear, and the reverse. A design that kept the old endian bit, or copied from the wrong position, shows the wrong bit 31.
- Vector gating: the data-stream class is driven while vector enable is clear. A missing exemption raises a spurious unavailable flag.

// File: rtl/exc_state_pkg.sv
// Shared constants and types for the exception state unit.
// Assumes big-endian bit numbering: architectural bit n is index XLEN-1-n.
package exc_state_pkg;
    localparam int XLEN = 32;

    // Index of architectural bit n.
    function automatic int be_idx(input int n);
        return XLEN - 1 - n;
    endfunction

    // Mask covering architectural bits lo..hi inclusive.
    function automatic logic [XLEN-1:0] be_range(input int lo, input int hi);
        logic [XLEN-1:0] m;
        m = '0;
        for (int b = lo; b <= hi; b++) m[XLEN-1-b] = 1'b1;
        return m;
    endfunction

    localparam int IDX_VEC = be_idx(6);
    localparam int IDX_ILE = be_idx(15);
    localparam int IDX_EE  = be_idx(16);
    localparam int IDX_PR  = be_idx(17);
    localparam int IDX_IR  = be_idx(26);
    localparam int IDX_DR  = be_idx(27);
    localparam int IDX_LE  = be_idx(31);

    localparam logic [XLEN-1:0] SAVE_MASK  = be_range(6, 6) | be_range(16, 31);
    localparam logic [XLEN-1:0] WRITE_MASK = be_range(6, 6) | be_range(13, 31);
    localparam logic [XLEN-1:0] ENTRY_CLR  = be_range(16, 17) | be_range(26, 27);

    typedef enum logic {
        TGT_STATE = 1'b0,
        TGT_SAVE  = 1'b1
    } wr_target_e;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SWWR   = 2'd1,
        OP_RETURN = 2'd2,
        OP_ENTER  = 2'd3
    } upd_op_e;
endpackage

// File: rtl/exc_op_arb.sv
// Chooses the update applied to each register this cycle.
// Assumes strobes are single-cycle; entry beats return beats software write.
module exc_op_arb
    import exc_state_pkg::*;
(
    input  logic     exc_enter,
    input  logic     exc_return,
    input  logic     wr_en,
    input  logic     wr_sel,
    output upd_op_e  st_op,
    output upd_op_e  sv_op
);
    // Pick the state-register update by fixed priority.
    always_comb begin
        if (exc_enter)                                      st_op = OP_ENTER;
        else if (exc_return)                                st_op = OP_RETURN;
        else if (wr_en && (wr_target_e'(wr_sel) == TGT_STATE)) st_op = OP_SWWR;
        else                                                st_op = OP_HOLD;
    end

    // Pick the save-register update; a return leaves it untouched.
    always_comb begin
        if (exc_enter)                                      sv_op = OP_ENTER;
        else if (exc_return)                                sv_op = OP_HOLD;
        else if (wr_en && (wr_target_e'(wr_sel) == TGT_SAVE))  sv_op = OP_SWWR;
        else                                                sv_op = OP_HOLD;
    end

    // R5: at most one register takes a software write, and never while a strobe is up.
    always_comb begin
        assert_sw_excl_R5: assert (!((st_op == OP_SWWR) && (sv_op == OP_SWWR)));
    end
endmodule

// File: rtl/exc_save_reg.sv
// Save/restore status register.
// Assumes the op comes from exc_op_arb; captures masked state on entry.
module exc_save_reg
    import exc_state_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  upd_op_e         op,
    input  logic [XLEN-1:0] state_in,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] save_q
);
    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) save_q <= '0;
        else begin
            case (op)
                OP_ENTER: save_q <= state_in & SAVE_MASK;
                OP_SWWR:  save_q <= wr_data;
                default:  save_q <= save_q;
            endcase
        end
    end

    // R2: entry snapshot holds only the selected state bits.
    assert_entry_snapshot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENTER) |=> (save_q == ($past(state_in) & SAVE_MASK)));

    // R6: software write lands unmasked.
    assert_sw_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SWWR) |=> (save_q == $past(wr_data)));
endmodule

// File: rtl/exc_state_reg.sv
// Live machine state register.
// Assumes the op comes from exc_op_arb; reserved positions forced to zero.
module exc_state_reg
    import exc_state_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  upd_op_e         op,
    input  logic [XLEN-1:0] save_in,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] state_q
);
    logic [XLEN-1:0] entry_val;

    // Build the handler-context state from the current state.
    always_comb begin
        entry_val          = state_q & ~ENTRY_CLR;
        entry_val[IDX_LE]  = state_q[IDX_ILE];
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else begin
            case (op)
                OP_ENTER:  state_q <= entry_val & WRITE_MASK;
                OP_RETURN: state_q <= save_in & WRITE_MASK;
                OP_SWWR:   state_q <= wr_data & WRITE_MASK;
                default:   state_q <= state_q;
            endcase
        end
    end

    // R3: handler state masks interrupts and takes byte order from the exception-endian bit.
    assert_entry_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENTER) |=> (!state_q[IDX_EE] && !state_q[IDX_PR] && !state_q[IDX_IR]
                              && !state_q[IDX_DR] && (state_q[IDX_LE] == $past(state_q[IDX_ILE]))));

    // R4: return restores the saved writable bits.
    assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RETURN) |=> (state_q == ($past(save_in) & WRITE_MASK)));

    // R9: reserved positions never hold a one.
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q & ~WRITE_MASK) == '0));
endmodule

// File: rtl/exc_gate.sv
// Combinational qualification of interrupt requests and vector availability.
// Assumes state_in is the live machine state.
module exc_gate
    import exc_state_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic [XLEN-1:0]  state_in,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             vec_op,
    input  logic             vec_stream,
    output logic [N_IRQ-1:0] irq_take,
    output logic             vec_unavail
);
    // One enable gate per interrupt source.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
        assign irq_take[g] = irq_req[g] & state_in[IDX_EE];
    end

    // Flag vector use while disabled, except the stream class.
    assign vec_unavail = vec_op & ~vec_stream & ~state_in[IDX_VEC];
endmodule

// File: rtl/exc_state_unit.sv
// Top: exception state save/restore with interrupt and vector gating.
// Assumes single-cycle strobes from the core's exception sequencer.
module exc_state_unit
    import exc_state_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_enter,
    input  logic             exc_return,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             vec_op,
    input  logic             vec_stream,
    output logic [31:0]      state_q,
    output logic [31:0]      save_q,
    output logic [N_IRQ-1:0] irq_take,
    output logic             vec_unavail
);
    upd_op_e st_op, sv_op;

    exc_op_arb u_arb (
        .exc_enter (exc_enter), .exc_return (exc_return),
        .wr_en (wr_en), .wr_sel (wr_sel),
        .st_op (st_op), .sv_op (sv_op)
    );

    exc_state_reg u_state (
        .clk (clk), .rst_n (rst_n), .op (st_op),
        .save_in (save_q), .wr_data (wr_data), .state_q (state_q)
    );

    exc_save_reg u_save (
        .clk (clk), .rst_n (rst_n), .op (sv_op),
        .state_in (state_q), .wr_data (wr_data), .save_q (save_q)
    );

    exc_gate #(.N_IRQ (N_IRQ)) u_gate (
        .state_in (state_q), .irq_req (irq_req),
        .vec_op (vec_op), .vec_stream (vec_stream),
        .irq_take (irq_take), .vec_unavail (vec_unavail)
    );

    // R5: a colliding return cannot undo entry's interrupt masking.
    assert_enter_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && exc_return) |=> !state_q[IDX_EE]);

    // R7: no request passes while interrupts are masked.
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q[IDX_EE] |-> (irq_take == '0));

    // R8: the stream class never flags unavailability.
    assert_stream_exempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_stream |-> !vec_unavail);

    // R1: registers are zero in the cycle after reset.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> ((state_q == '0) && (save_q == '0)));
endmodule

// File: tb/sim_exc_state_unit.sv
`timescale 1ns/1ps
module sim_exc_state_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_enter = 0, exc_return = 0, wr_en = 0, wr_sel = 0;
    logic [31:0] wr_data = '0;
    logic [1:0]  irq_req = '0;
    logic        vec_op = 0, vec_stream = 0;
    logic [31:0] state_q, save_q;
    logic [1:0]  irq_take;
    logic        vec_unavail;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    exc_state_unit #(.N_IRQ(2)) u0 (
        .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_return(exc_return),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_req(irq_req),
        .vec_op(vec_op), .vec_stream(vec_stream), .state_q(state_q), .save_q(save_q),
        .irq_take(irq_take), .vec_unavail(vec_unavail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Fields: {enter, ret, wr_en, wr_sel, wr_data, exp_state, exp_save}
    localparam logic [99:0] TAB [12] = '{
        {4'b0010, 32'hFFFF_FFFF, 32'h0207_FFFF, 32'h0000_0000}, // R6 R9 state write masked
        {4'b0011, 32'hA5A5_A5A5, 32'h0207_FFFF, 32'hA5A5_A5A5}, // R6 save write full
        {4'b1000, 32'h0000_0000, 32'h0207_3FCF, 32'h0200_FFFF}, // R2 R3 entry
        {4'b0100, 32'h0000_0000, 32'h0200_FFFF, 32'h0200_FFFF}, // R4 return
        {4'b0010, 32'h0001_0000, 32'h0001_0000, 32'h0200_FFFF}, // R6 exception-endian only
        {4'b1000, 32'h0000_0000, 32'h0001_0001, 32'h0000_0000}, // R3 LE from ILE, R2 ILE not saved
        {4'b0011, 32'hFFFF_FFFF, 32'h0001_0001, 32'hFFFF_FFFF}, // R6 save all ones
        {4'b0100, 32'h0000_0000, 32'h0207_FFFF, 32'hFFFF_FFFF}, // R4 R9 reserved stay zero
        {4'b1100, 32'h0000_0000, 32'h0207_3FCF, 32'h0200_FFFF}, // R5 entry beats return
        {4'b0110, 32'h0000_0000, 32'h0200_FFFF, 32'h0200_FFFF}, // R5 return beats write
        {4'b0010, 32'h0000_0001, 32'h0000_0001, 32'h0200_FFFF}, // R6 LE set, ILE clear
        {4'b1000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001}  // R3 LE cleared, R2
    };

    task automatic step(input logic en, input logic rt, input logic we, input logic sel,
                        input logic [31:0] d);
        @(negedge clk);
        exc_enter = en; exc_return = rt; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        exc_enter = 0; exc_return = 0; wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 state", state_q, 32'h0);
        check("R1 save", save_q, 32'h0);
        irq_req = 2'b11; #1;
        check("R1 irq masked", {30'h0, irq_take}, 32'h0);
        irq_req = 2'b00;
        rst_n = 1'b1;

        for (int i = 0; i < 12; i++) begin
            step(TAB[i][99], TAB[i][98], TAB[i][97], TAB[i][96], TAB[i][95:64]);
            check($sformatf("vec%0d state", i), state_q, TAB[i][63:32]);
            check($sformatf("vec%0d save", i), save_q, TAB[i][31:0]);
        end

        // R7 interrupt gating
        step(0, 0, 1, 0, 32'h0000_8000);
        irq_req = 2'b10; #1;
        check("R7 enabled", {30'h0, irq_take}, 32'h2);
        irq_req = 2'b11; #1;
        check("R7 enabled both", {30'h0, irq_take}, 32'h3);
        step(0, 0, 1, 0, 32'h0000_0000);
        #1;
        check("R7 disabled", {30'h0, irq_take}, 32'h0);
        irq_req = 2'b00;

        // R8 vector gating (state bit 6 = 0 now)
        vec_op = 1; vec_stream = 0; #1;
        check("R8 unavailable", {31'h0, vec_unavail}, 32'h1);
        vec_stream = 1; #1;
        check("R8 stream exempt", {31'h0, vec_unavail}, 32'h0);
        vec_stream = 0;
        step(0, 0, 1, 0, 32'h0200_0000);
        #1;
        check("R8 enabled", {31'h0, vec_unavail}, 32'h0);
        vec_op = 0; #1;
        check("R8 no op", {31'h0, vec_unavail}, 32'h0);

        // R1 reset mid-run
        step(0, 0, 1, 1, 32'h1234_5678);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset state", state_q, 32'h0);
        check("R1 re-reset save", save_q, 32'h0);
        rst_n = 1'b1;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule